// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block gathers eight interrupt inputs, latches their rising edges into a request register, and raises one interrupt line towards a processor. It picks the lowest-numbered request that is unmasked and that outranks every interrupt already being serviced. Software reaches the block through a byte-wide port with two addresses: an even address for initialization starts and operation commands, and an odd address for the remaining initialization words and the mask register.

The block is set up by an ordered sequence of initialization words. These set a vector base, a cascade word and a mode word, and the mode word can select automatic end of interrupt. A one-cycle acknowledge strobe stands in for the processor's acknowledge bus cycle. In that cycle the block puts out the vector byte and moves the winning request into the in-service register. A specific or a non-specific end-of-interrupt command clears an in-service bit later. A request that is withdrawn before acknowledge gives the vector for the highest-numbered input, and no in-service bit is set, so software can tell it was not genuine.

Top module: `legacy_pic`

## Requirements
- R1: After reset, int_o is low, the mask reads 0xFF at the odd address, and the request register reads 0x00 at the even address. int_o stays low until an initialization sequence completes.
- R2: A write to the even address with bit 4 set starts initialization. It clears the mask, the request register and the in-service register. It selects request-register read-back and clears automatic EOI. An input that is already high must then go low and rise again before it is latched. Operation commands (odd-address mask writes and even-address commands with bit 4 clear) are ignored until the last initialization word.
- R3: After the start word, odd-address writes are taken in a fixed order. The vector base comes first. The cascade word comes next, unless start-word bit 1 (single) is set. The mode word comes last, unless start-word bit 0 (fourth word expected) is clear. The cascade word appears on casc_o.
- R4: Bit 1 of the mode word enables automatic EOI. When the mode word is skipped, normal EOI applies.
- R5: Once initialized, an odd-address write loads the 8-bit mask, where 1 masks the input. An odd-address read returns the mask. A masked request never drives int_o.
- R6: A request bit is set by a rising edge of its input seen at a clock edge. It is cleared if the input falls before acknowledge. Request-register read-back shows it.
- R7: int_o is high when the lowest-numbered unmasked pending request has a lower index than every set in-service bit.
- R8: In a cycle with inta_i high and int_o high, vec_o equals base plus the winning index. At that clock edge the winner's request bit clears, and its in-service bit sets unless automatic EOI is on.
- R9: In automatic-EOI mode an acknowledge sets no in-service bit.
- R10: An acknowledge while int_o is low returns vec_o = base + 7 and leaves the in-service register unchanged.
- R11: An even-address write of 0x0A selects request-register read-back and 0x0B selects in-service read-back (bit 3 set, bit 1 = change, bit 0 = in-service). If bit 1 is clear, the selection is left as it is.
- R12: An even-address write of 0x60+n (bits 7:5 = 011) clears in-service bit n only.
- R13: An even-address write of 0x20 (bits 7:5 = 001) clears the lowest-numbered set in-service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register address: 0 even, 1 odd |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| irq_i | input | 8 | Interrupt request inputs |
| int_o | output | 1 | Interrupt to the processor |
| inta_i | input | 1 | One-cycle acknowledge strobe |
| vec_o | output | 8 | Vector byte, valid while inta_i is high, else 0 |
| casc_o | output | 8 | Stored cascade word |

## Verification
Inputs are applied at the falling edge. Read data and vec_o depend on that cycle's address and strobe, so they are due in the same cycle. A rising input edge shows up on int_o and in request read-back one clock later. The effect of a write or an acknowledge on the mask, selection or in-service state is visible from the next cycle. The bench keeps a per-cycle expected model that it advances only at each rising edge, and compares every output 1 ns after the inputs change. Each result is therefore checked in exactly the cycle in which it is due.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {ST_RUN = 2'd0, ST_BASE, ST_CASC, ST_MODE} init_st_e;
  localparam int unsigned INIT_BIT = 4;
  localparam int unsigned OCW3_BIT = 3;
  localparam logic [2:0] EOI_NS = 3'b001;
  localparam logic [2:0] EOI_SP = 3'b011;
endpackage

// File: rtl/pic_cfg.sv
module pic_cfg
  import pic_pkg::*;
#(
  parameter int unsigned N_IRQ = 8,
  parameter int unsigned DW    = 8,
  localparam int unsigned IDX_W = $clog2(N_IRQ)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic             init_o,
  output logic             done_o,
  output logic [DW-1:0]    base_o,
  output logic [DW-1:0]    casc_o,
  output logic             aeoi_o,
  output logic [N_IRQ-1:0] imr_o,
  output logic             rd_isr_o,
  output logic             eoi_sp_o,
  output logic             eoi_ns_o,
  output logic [IDX_W-1:0] eoi_lvl_o
);
  init_st_e st_q;
  logic ic4_q, single_q;
  logic even_wr, odd_wr, ocw2, ocw3;

  assign even_wr   = wr_i & ~addr_i;
  assign odd_wr    = wr_i & addr_i;
  assign init_o    = even_wr & wdata_i[INIT_BIT];
  assign ocw3      = even_wr & ~wdata_i[INIT_BIT] & wdata_i[OCW3_BIT] & done_o;
  assign ocw2      = even_wr & ~wdata_i[INIT_BIT] & ~wdata_i[OCW3_BIT] & done_o;
  assign eoi_sp_o  = ocw2 & (wdata_i[7:5] == EOI_SP);
  assign eoi_ns_o  = ocw2 & (wdata_i[7:5] == EOI_NS);
  assign eoi_lvl_o = wdata_i[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_RUN;
      done_o   <= 1'b0;
      base_o   <= '0;
      casc_o   <= '0;
      aeoi_o   <= 1'b0;
      imr_o    <= '1;
      rd_isr_o <= 1'b0;
      ic4_q    <= 1'b0;
      single_q <= 1'b0;
    end else if (init_o) begin
      st_q     <= ST_BASE;
      done_o   <= 1'b0;
      ic4_q    <= wdata_i[0];
      single_q <= wdata_i[1];
      aeoi_o   <= 1'b0;
      imr_o    <= '0;
      rd_isr_o <= 1'b0;
    end else begin
      if (ocw3 && wdata_i[1]) rd_isr_o <= wdata_i[0];
      if (odd_wr) begin
        unique case (st_q)
          ST_BASE: begin
            base_o <= wdata_i;
            if (!single_q) st_q <= ST_CASC;
            else if (ic4_q) st_q <= ST_MODE;
            else begin st_q <= ST_RUN; done_o <= 1'b1; end
          end
          ST_CASC: begin
            casc_o <= wdata_i;
            if (ic4_q) st_q <= ST_MODE;
            else begin st_q <= ST_RUN; done_o <= 1'b1; end
          end
          ST_MODE: begin
            aeoi_o <= wdata_i[1];
            st_q   <= ST_RUN;
            done_o <= 1'b1;
          end
          default: if (done_o) imr_o <= wdata_i[N_IRQ-1:0];
        endcase
      end
    end
  end

  // R3: init sequence must reach run state before commands are honoured
  a_r3_done_in_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> st_q == ST_RUN);
  // R4: auto EOI cleared by a new start word
  a_r4_aeoi_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_o |=> !aeoi_o && !done_o);
endmodule

// File: rtl/pic_resolver.sv
module pic_resolver #(
  parameter int unsigned N_IRQ = 8,
  localparam int unsigned IDX_W = $clog2(N_IRQ)
) (
  input  logic [N_IRQ-1:0] irr_i,
  input  logic [N_IRQ-1:0] isr_i,
  input  logic [N_IRQ-1:0] imr_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] win_o,
  output logic             isr_any_o,
  output logic [IDX_W-1:0] isr_low_o
);
  logic [N_IRQ-1:0] pend;
  logic             p_any;

  assign pend = irr_i & ~imr_i;

  always_comb begin
    p_any     = 1'b0;
    win_o     = '0;
    isr_any_o = 1'b0;
    isr_low_o = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (pend[i])  begin p_any = 1'b1;     win_o = IDX_W'(i);     end
      if (isr_i[i]) begin isr_any_o = 1'b1; isr_low_o = IDX_W'(i); end
    end
    valid_o = p_any & (~isr_any_o | (win_o < isr_low_o));
  end
endmodule

// File: rtl/legacy_pic.sv
module legacy_pic #(
  parameter int unsigned N_IRQ = 8,
  parameter int unsigned DW    = 8,
  localparam int unsigned IDX_W = $clog2(N_IRQ)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [N_IRQ-1:0] irq_i,
  output logic             int_o,
  input  logic             inta_i,
  output logic [DW-1:0]    vec_o,
  output logic [DW-1:0]    casc_o
);
  logic             init, done, aeoi, rd_isr, eoi_sp, eoi_ns;
  logic [DW-1:0]    base;
  logic [N_IRQ-1:0] imr, irr_q, isr_q, req_q;
  logic [IDX_W-1:0] eoi_lvl, win_idx, isr_low;
  logic             win_valid, isr_any, ack_fire;

  pic_cfg #(.N_IRQ(N_IRQ), .DW(DW)) u_cfg (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .init_o(init), .done_o(done), .base_o(base), .casc_o(casc_o),
    .aeoi_o(aeoi), .imr_o(imr), .rd_isr_o(rd_isr),
    .eoi_sp_o(eoi_sp), .eoi_ns_o(eoi_ns), .eoi_lvl_o(eoi_lvl)
  );

  pic_resolver #(.N_IRQ(N_IRQ)) u_res (
    .irr_i(irr_q), .isr_i(isr_q), .imr_i(imr),
    .valid_o(win_valid), .win_o(win_idx),
    .isr_any_o(isr_any), .isr_low_o(isr_low)
  );

  assign int_o    = done & win_valid;
  assign ack_fire = inta_i & int_o;

  for (genvar g = 0; g < N_IRQ; g++) begin : g_line
    logic ack_hit, clr_hit, rise;
    assign ack_hit = ack_fire & (win_idx == IDX_W'(g));
    assign clr_hit = (eoi_sp & (eoi_lvl == IDX_W'(g))) |
                     (eoi_ns & isr_any & (isr_low == IDX_W'(g)));
    assign rise    = irq_i[g] & ~req_q[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        irr_q[g] <= 1'b0;
        isr_q[g] <= 1'b0;
        req_q[g] <= 1'b1;
      end else if (init) begin
        irr_q[g] <= 1'b0;
        isr_q[g] <= 1'b0;
        req_q[g] <= 1'b1;  // demand a fresh edge after init
      end else begin
        irr_q[g] <= ((irr_q[g] & ~ack_hit) | rise) & irq_i[g];
        isr_q[g] <= (isr_q[g] | (ack_hit & ~aeoi)) & ~clr_hit;
        req_q[g] <= irq_i[g];
      end
    end
  end

  assign rdata_o = addr_i ? DW'(imr) : (rd_isr ? DW'(isr_q) : DW'(irr_q));
  assign vec_o   = inta_i ? base + (int_o ? DW'(win_idx) : DW'(N_IRQ - 1)) : '0;

  // R5: a raised interrupt always has an unmasked pending source
  a_r5_int_unmasked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> (irr_q & ~imr) != '0);
  // R8: acknowledge consumes the request bit
  a_r8_ack_clears_irr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_fire && !init |=> !irr_q[$past(win_idx)]);
  // R8: acknowledge in normal mode marks in-service
  a_r8_ack_sets_isr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_fire && !aeoi && !wr_i |=> isr_q[$past(win_idx)]);
  // R9: auto EOI leaves in-service untouched
  a_r9_aeoi_keeps_isr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_i && aeoi && !wr_i |=> isr_q == $past(isr_q));
  // R10: spurious acknowledge leaves in-service untouched
  a_r10_spurious_keeps_isr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_i && !int_o && !wr_i |=> isr_q == $past(isr_q));
  // R2: start word wipes request, service and mask state
  a_r2_init_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init |=> irr_q == '0 && isr_q == '0 && imr == '0 && !int_o);
endmodule

// File: tb/legacy_pic_tb.sv
`timescale 1ns/1ps
module legacy_pic_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0, addr = 1'b0, inta = 1'b0;
  logic [7:0] wdata = '0, irq = '0;
  logic [7:0] rdata, vec, casc;
  logic int_w;

  // staged inputs, applied at the falling edge
  logic s_wr = 1'b0, s_addr = 1'b0, s_inta = 1'b0;
  logic [7:0] s_wdata = '0, s_irq = '0;

  int checks = 0, fails = 0;
  string tag = "R1";
  logic [7:0] obs_rd, obs_vec;
  logic obs_int;

  // expected-state model
  logic [7:0] m_imr = 8'hFF, m_irr = '0, m_isr = '0, m_base = '0, m_casc = '0, m_reqq = 8'hFF;
  logic m_sel = 0, m_aeoi = 0, m_done = 0, m_ic4 = 0, m_single = 0;
  int m_st = 0;  // 0 run, 1 base, 2 cascade, 3 mode

  always #2.5 clk = ~clk;

  legacy_pic u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_i(irq), .int_o(int_w), .inta_i(inta),
    .vec_o(vec), .casc_o(casc)
  );

  function automatic int lowest(logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic logic m_valid();
    logic [7:0] p;
    p = m_irr & ~m_imr;
    return m_done && p != 0 && lowest(p) < lowest(m_isr);
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL [%s] %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    logic [7:0] ackb, clrb, setb;
    ackb = '0; clrb = '0; setb = '0;
    if (s_wr && !s_addr && s_wdata[4]) begin
      m_imr = '0; m_irr = '0; m_isr = '0; m_sel = 0; m_reqq = 8'hFF;
      m_st = 1; m_done = 0; m_ic4 = s_wdata[0]; m_single = s_wdata[1]; m_aeoi = 0;
      return;
    end
    if (s_inta && m_valid()) begin
      ackb = 8'(1 << lowest(m_irr & ~m_imr));
      if (!m_aeoi) setb = ackb;
    end
    if (m_done && s_wr && !s_addr && !s_wdata[3]) begin
      if (s_wdata[7:5] == 3'b011) clrb = 8'(1 << s_wdata[2:0]);
      if (s_wdata[7:5] == 3'b001 && m_isr != 0) clrb = 8'(1 << lowest(m_isr));
    end
    if (m_done && s_wr && !s_addr && s_wdata[3] && s_wdata[1]) m_sel = s_wdata[0];
    if (s_wr && s_addr) begin
      case (m_st)
        1: begin
          m_base = s_wdata;
          if (!m_single) m_st = 2; else if (m_ic4) m_st = 3; else begin m_st = 0; m_done = 1; end
        end
        2: begin
          m_casc = s_wdata;
          if (m_ic4) m_st = 3; else begin m_st = 0; m_done = 1; end
        end
        3: begin m_aeoi = s_wdata[1]; m_st = 0; m_done = 1; end
        default: if (m_done) m_imr = s_wdata;
      endcase
    end
    m_isr  = (m_isr | setb) & ~clrb;
    m_irr  = ((m_irr & ~ackb) | (s_irq & ~m_reqq)) & s_irq;
    m_reqq = s_irq;
  endtask

  task automatic tick();
    logic [7:0] e_rd, e_vec;
    @(negedge clk);
    wr = s_wr; addr = s_addr; wdata = s_wdata; irq = s_irq; inta = s_inta;
    #1;
    e_rd  = s_addr ? m_imr : (m_sel ? m_isr : m_irr);
    e_vec = s_inta ? m_base + (m_valid() ? 8'(lowest(m_irr & ~m_imr)) : 8'd7) : 8'd0;
    chk("int_o", 32'(int_w), 32'(m_valid()));
    chk("rdata_o", 32'(rdata), 32'(e_rd));
    chk("vec_o", 32'(vec), 32'(e_vec));
    chk("casc_o", 32'(casc), 32'(m_casc));
    obs_rd = rdata; obs_vec = vec; obs_int = int_w;
    @(posedge clk);
    model_step();
  endtask

  task automatic wreg(logic a, logic [7:0] d);
    s_wr = 1; s_addr = a; s_wdata = d; tick(); s_wr = 0; s_addr = 0;
  endtask

  task automatic rreg(logic a);
    s_addr = a; tick(); s_addr = 0;
  endtask

  task automatic ack();
    s_inta = 1; tick(); s_inta = 0;
  endtask

  task automatic init4(logic [7:0] b, logic [7:0] c, logic [7:0] m);
    wreg(0, 8'h11); wreg(1, b); wreg(1, c); wreg(1, m);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL [watchdog] run did not finish: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    tag = "R1";
    rreg(1); chk("mask after reset", 32'(obs_rd), 32'hFF);
    rreg(0); chk("irr after reset", 32'(obs_rd), 32'h00);
    s_irq = 8'h01; tick(); tick(); chk("int before init", 32'(obs_int), 0);
    s_irq = 8'h00; tick();

    tag = "R2";
    s_irq = 8'h01; tick();            // held high across init
    init4(8'h20, 8'h04, 8'h01);
    rreg(1); chk("mask cleared by init", 32'(obs_rd), 32'h00);
    tag = "R6";
    tick(); chk("held input needs fresh edge", 32'(obs_int), 0);
    s_irq = 8'h00; tick(); s_irq = 8'h01; tick();
    tick(); chk("rising edge raises int", 32'(obs_int), 1);
    s_irq = 8'h00; tick();
    rreg(0); chk("withdrawn request cleared", 32'(obs_rd), 32'h00);

    tag = "R3";
    chk("cascade word", 32'(casc), 32'h04);

    tag = "R8";
    s_irq = 8'h08; tick(); tick();
    ack(); chk("vector for input 3", 32'(obs_vec), 32'h23);
    tag = "R11";
    wreg(0, 8'h0B); rreg(0); chk("isr readback", 32'(obs_rd), 32'h08);
    wreg(0, 8'h08); rreg(0); chk("select kept without change bit", 32'(obs_rd), 32'h08);
    tag = "R7";
    s_irq = 8'h28; tick(); tick(); chk("lower priority blocked", 32'(obs_int), 0);
    s_irq = 8'h2A; tick(); tick(); chk("higher priority nests", 32'(obs_int), 1);
    ack(); chk("vector for input 1", 32'(obs_vec), 32'h21);
    tag = "R13";
    wreg(0, 8'h20); rreg(0); chk("non-specific EOI", 32'(obs_rd), 32'h08);
    tag = "R12";
    wreg(0, 8'h60); rreg(0); chk("specific EOI on clear bit", 32'(obs_rd), 32'h08);
    wreg(0, 8'h63); rreg(0); chk("specific EOI input 3", 32'(obs_rd), 32'h00);
    tag = "R5";
    wreg(1, 8'h20); tick(); chk("masked input 5 silent", 32'(obs_int), 0);
    rreg(1); chk("mask readback", 32'(obs_rd), 32'h20);
    wreg(1, 8'h00); tick(); chk("unmasked input 5", 32'(obs_int), 1);
    ack(); wreg(0, 8'h65); s_irq = 8'h00; tick();

    tag = "R10";
    s_irq = 8'h40; tick(); s_irq = 8'h00; tick();
    ack(); chk("spurious vector", 32'(obs_vec), 32'h27);
    wreg(0, 8'h0B); rreg(0); chk("spurious leaves isr", 32'(obs_rd), 32'h00);

    tag = "R3";
    wreg(0, 8'h12); wreg(1, 8'h40);
    wreg(1, 8'h80); rreg(1); chk("single, no mode word: mask live", 32'(obs_rd), 32'h80);
    chk("cascade untouched", 32'(casc), 32'h04);
    tag = "R4";
    s_irq = 8'h01; tick(); tick();
    ack(); chk("vector base 0x40", 32'(obs_vec), 32'h40);
    wreg(0, 8'h0B); rreg(0); chk("normal EOI default", 32'(obs_rd), 32'h01);
    s_irq = 8'h00; tick();

    tag = "R9";
    init4(8'h08, 8'h02, 8'h03);
    chk("slave id", 32'(casc), 32'h02);
    s_irq = 8'h04; tick(); tick();
    ack(); chk("vector auto EOI", 32'(obs_vec), 32'h0A);
    wreg(0, 8'h0B); rreg(0); chk("auto EOI no isr", 32'(obs_rd), 32'h00);
    s_irq = 8'h00; tick();

    tag = "R7";
    init4(8'h30, 8'h04, 8'h01);
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (($urandom_range(0, 3)) == 0) s_irq = s_irq ^ (8'($urandom) & 8'($urandom));
      s_addr = 1'($urandom);
      if (r < 12) s_inta = 1;
      else if (r < 30) begin
        int k;
        k = int'($urandom_range(0, 9));
        s_wr = 1;
        case (k)
          0, 1:    begin s_addr = 1; s_wdata = 8'($urandom) & 8'($urandom); end
          2:       begin s_addr = 0; s_wdata = 8'h0A; end
          3:       begin s_addr = 0; s_wdata = 8'h0B; end
          4, 5:    begin s_addr = 0; s_wdata = 8'h20; end
          6, 7:    begin s_addr = 0; s_wdata = 8'h60 | 8'($urandom_range(0, 7)); end
          8:       begin s_addr = 0; s_wdata = (n % 7 == 0) ? (8'h10 | 8'($urandom_range(0, 3))) : 8'h08; end
          default: begin s_addr = 1; s_wdata = 8'($urandom); end
        endcase
      end
      tick();
      s_wr = 0; s_inta = 0;
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule